// File: doc/BRIEF.md
# Three-Stage Cascade Noise Cancellation Combiner

This block takes the three one-bit decisions of a cascaded sigma-delta modulator and merges them into one signed fixed-point word per sample. The modulator is a second-order loop followed by two first-order loops. Each stage's bit stream passes through its own matching filter: the first stage is delayed, the second stage goes through a second-order difference and a one-sample delay, and the third stage goes through a third-order difference. The quantization error of the first two loops cancels, and only the last quantizer's error remains, shaped to fourth order. The middle matching term is zero and has no hardware. The result goes to a decimation filter that is not part of this block.

Samples arrive on a strobe, at up to one per clock. The two matching gains are signed fixed-point inputs with `FRAC_W` fraction bits. They are sampled on the strobe cycle, so software-side registers may change them between samples. A four-state fill controller counts the first samples after reset: `FILL_EMPTY` goes to `FILL_ONE`, then to `FILL_TWO`, then to `FILL_FULL`, advancing one step on each strobe and staying put without one. `FILL_FULL` is kept until reset. The output word and its valid flag are produced only in `FILL_FULL`.

Top module: `mash211_cancel`

## Requirements
- R1: During and after reset, before any full-history sample, `out_valid` is 0 and `out_word` is 0.
- R2: Each input bit is taken as the level +1 when 1 and -1 when 0. With all three inputs held at 1, every difference term is zero and the word is +2^FRAC_W. With all three held at 0, it is -2^FRAC_W.
- R3: For strobe index k (counted from 0 after reset), the word equals 2^FRAC_W·a[k-2] + gain_two·(b[k-1] - 2b[k-2] + b[k-3]) + gain_three·(c[k] - 3c[k-1] + 3c[k-2] - c[k-3]). Here a, b and c are the levels of `bit_first`, `bit_second` and `bit_third`. The result is exact, with FRAC_W fraction bits and no rounding.
- R4: `out_valid` is 1 exactly in the clock after a strobe with index 3 or more, and 0 otherwise. The first three strobes after reset yield no valid word.
- R5: A cycle with `sample_stb` low changes no history. It also leaves `out_word` unchanged.
- R6: The word never overflows, even at the most negative gains combined with the largest difference magnitudes (±4 for the second-order term, ±8 for the third-order term).
- R7: The gains are used as they stand in the strobe cycle. A new value presented in the same cycle as a strobe applies to that sample.
- R8: Strobes in consecutive clocks are each processed, with one word per strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | High for one cycle per modulator sample |
| bit_first | input | 1 | Decision of the second-order first loop |
| bit_second | input | 1 | Decision of the first first-order loop |
| bit_third | input | 1 | Decision of the last first-order loop |
| gain_two | input | COEF_W | Signed gain on the second-stage path, FRAC_W fraction bits |
| gain_three | input | COEF_W | Signed gain on the third-stage path, FRAC_W fraction bits |
| out_word | output | COEF_W+5 | Signed combined sample, FRAC_W fraction bits |
| out_valid | output | 1 | High one cycle after each full-history strobe |

## Verification
A gain update can land in the same clock as a sample strobe. So can the strobe that finishes filling the history and the first calculation of a word. The bench changes both gains on the very cycle of a strobe and compares the word against the formula evaluated with the new gains. It also checks that the fourth strobe after reset, and no earlier one, brings out a valid word whose value already uses the complete history. Idle gaps between strobes are checked for a frozen output, and bit streams from an integer model of the three loops are compared sample by sample.

// File: rtl/mnc_pkg.sv
package mnc_pkg;

    // Width that carries a level of +-1 through up to three differences (+-8).
    localparam int DIFF_W = 5;

    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_ONE   = 2'd1,
        FILL_TWO   = 2'd2,
        FILL_FULL  = 2'd3
    } fill_state_t;

    // One-bit decision to signed level: 1 -> +1, 0 -> -1.
    function automatic logic signed [DIFF_W-1:0] to_level(input logic b);
        logic signed [DIFF_W-1:0] r;
        if (b) begin
            r = {{(DIFF_W-1){1'b0}}, 1'b1};
        end else begin
            r = {DIFF_W{1'b1}};
        end
        return r;
    endfunction

endpackage

// File: rtl/mnc_diff_chain.sv
// Cascade of ORDER first differences; each stage keeps its previous input.
module mnc_diff_chain #(
    parameter int ORDER = 2,
    parameter int W     = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic signed [W-1:0] x,
    output logic signed [W-1:0] d
);

    logic signed [W-1:0] stg [0:ORDER];

    assign stg[0] = x;

    for (genvar i = 0; i < ORDER; i++) begin : g_stage
        logic signed [W-1:0] prev;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev <= '0;
            end else if (en) begin
                prev <= stg[i];
            end
        end

        assign stg[i+1] = stg[i] - prev;
    end

    assign d = stg[ORDER];

    // Inputs are levels in {-1,0,+1}, so an ORDER-th difference stays in +-2^ORDER.
    AST_DIFF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> ((int'(d) <= (1 << ORDER)) && (int'(d) >= -(1 << ORDER)))); // R6

endmodule

// File: rtl/mnc_delay.sv
// Strobe-enabled delay line of DEPTH samples.
module mnc_delay #(
    parameter int DEPTH = 2,
    parameter int W     = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic signed [W-1:0] x,
    output logic signed [W-1:0] q
);

    logic signed [W-1:0] tap [0:DEPTH];

    assign tap[0] = x;

    for (genvar i = 0; i < DEPTH; i++) begin : g_tap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tap[i+1] <= '0;
            end else if (en) begin
                tap[i+1] <= tap[i];
            end
        end
    end

    assign q = tap[DEPTH];

endmodule

// File: rtl/mnc_fill_fsm.sv
// Counts the first strobes after reset until every history register holds a real sample.
module mnc_fill_fsm
    import mnc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stb,
    output fill_state_t state,
    output logic        full
);

    fill_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FILL_EMPTY;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            FILL_EMPTY: if (stb) state_nx = FILL_ONE;
            FILL_ONE:   if (stb) state_nx = FILL_TWO;
            FILL_TWO:   if (stb) state_nx = FILL_FULL;
            FILL_FULL:  state_nx = FILL_FULL;
            default:    state_nx = FILL_EMPTY;
        endcase
    end

    always_comb begin
        full = 1'b0;
        unique case (state)
            FILL_EMPTY, FILL_ONE, FILL_TWO: full = 1'b0;
            FILL_FULL:                      full = 1'b1;
            default:                        full = 1'b0;
        endcase
    end

    AST_FSM_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(state)); // R5
    AST_FSM_FULL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FILL_FULL) |=> (state == FILL_FULL)); // R4

endmodule

// File: rtl/mash211_cancel.sv
module mash211_cancel
    import mnc_pkg::*;
#(
    parameter int COEF_W = 12,
    parameter int FRAC_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_stb,
    input  logic                     bit_first,
    input  logic                     bit_second,
    input  logic                     bit_third,
    input  logic signed [COEF_W-1:0] gain_two,
    input  logic signed [COEF_W-1:0] gain_three,
    output logic signed [COEF_W+4:0] out_word,
    output logic                     out_valid
);

    // Output width: 2^FRAC_W + 12*2^(COEF_W-1) fits in COEF_W+5 signed bits.
    localparam int OUT_W = COEF_W + 5;
    // Magnitude limit used by the range check, one bit wider than the output.
    localparam logic signed [OUT_W:0] LIMIT = (OUT_W + 1)'(13) <<< (COEF_W - 1);

    logic signed [DIFF_W-1:0] lvl_a, lvl_b, lvl_c;
    logic signed [DIFF_W-1:0] a_late;
    logic signed [DIFF_W-1:0] b_diff2, b_diff2_late;
    logic signed [DIFF_W-1:0] c_diff3;
    logic signed [OUT_W-1:0]  term_a, term_b, term_c, total;
    fill_state_t              fill_state;
    logic                     hist_full;

    assign lvl_a = to_level(bit_first);
    assign lvl_b = to_level(bit_second);
    assign lvl_c = to_level(bit_third);

    // First path: plain delay, one for its own filter and one for the second combine.
    mnc_delay #(.DEPTH(2), .W(DIFF_W)) i_delay_a (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sample_stb),
        .x     (lvl_a),
        .q     (a_late)
    );

    // Second path: second-order difference, then the second combine's delay.
    mnc_diff_chain #(.ORDER(2), .W(DIFF_W)) i_diff_b (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sample_stb),
        .x     (lvl_b),
        .d     (b_diff2)
    );

    mnc_delay #(.DEPTH(1), .W(DIFF_W)) i_delay_b (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sample_stb),
        .x     (b_diff2),
        .q     (b_diff2_late)
    );

    // Third path: third-order difference, no delay.
    mnc_diff_chain #(.ORDER(3), .W(DIFF_W)) i_diff_c (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sample_stb),
        .x     (lvl_c),
        .d     (c_diff3)
    );

    mnc_fill_fsm i_fill (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (sample_stb),
        .state (fill_state),
        .full  (hist_full)
    );

    // Weighting and sum; gains are taken as they stand in the strobe cycle.
    assign term_a = OUT_W'(a_late) <<< FRAC_W;
    assign term_b = OUT_W'(gain_two) * OUT_W'(b_diff2_late);
    assign term_c = OUT_W'(gain_three) * OUT_W'(c_diff3);
    assign total  = term_a + term_b + term_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_word  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= sample_stb && hist_full;
            if (sample_stb && hist_full) begin
                out_word <= total;
            end
        end
    end

    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(sample_stb)); // R4
    AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && (fill_state != FILL_FULL)) |=> !out_valid); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> $stable(out_word)); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (($signed({out_word[OUT_W-1], out_word}) <= LIMIT) &&
                       ($signed({out_word[OUT_W-1], out_word}) >= -LIMIT))); // R6

endmodule

// File: tb/test_mash211_cancel.sv
`timescale 1ns/1ps
module test_mash211_cancel;

    localparam int CW = 12;
    localparam int FW = 8;
    localparam int OW = CW + 5;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 sample_stb = 1'b0;
    logic                 bit_first = 1'b0;
    logic                 bit_second = 1'b0;
    logic                 bit_third = 1'b0;
    logic signed [CW-1:0] gain_two = '0;
    logic signed [CW-1:0] gain_three = '0;
    logic signed [OW-1:0] out_word;
    logic                 out_valid;

    int checks = 0;
    int errors = 0;

    // Bench history of levels: index 0 is the newest sample.
    int ha [0:3];
    int hb [0:3];
    int hc [0:3];
    int nsamp;
    longint last_word;

    always #5 clk = ~clk;

    mash211_cancel #(.COEF_W(CW), .FRAC_W(FW)) i_mash211_cancel (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .bit_first  (bit_first),
        .bit_second (bit_second),
        .bit_third  (bit_third),
        .gain_two   (gain_two),
        .gain_three (gain_three),
        .out_word   (out_word),
        .out_valid  (out_valid)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        sample_stb = 1'b0;
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            ha[i] = 0; hb[i] = 0; hc[i] = 0;
        end
        nsamp = 0;
        last_word = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Drive one sample at a falling edge, check the registered result one clock later.
    task automatic push(input bit b1, input bit b2, input bit b3, input bit keep, input string tag);
        longint expw;
        bit     expv;
        bit_first = b1; bit_second = b2; bit_third = b3;
        sample_stb = 1'b1;
        for (int i = 3; i > 0; i--) begin
            ha[i] = ha[i-1]; hb[i] = hb[i-1]; hc[i] = hc[i-1];
        end
        ha[0] = b1 ? 1 : -1;
        hb[0] = b2 ? 1 : -1;
        hc[0] = b3 ? 1 : -1;
        expv = (nsamp >= 3);
        expw = longint'(ha[2]) * (longint'(1) << FW)
             + longint'(gain_two) * longint'(hb[1] - 2 * hb[2] + hb[3])
             + longint'(gain_three) * longint'(hc[0] - 3 * hc[1] + 3 * hc[2] - hc[3]);
        nsamp++;
        @(negedge clk);
        if (!keep) sample_stb = 1'b0;
        chk(out_valid == expv, {tag, " R4 valid"}, longint'(out_valid), longint'(expv));
        if (expv) begin
            chk(longint'(out_word) == expw, {tag, " R3 word"}, longint'(out_word), expw);
            last_word = expw;
        end
    endtask

    task automatic idle(input int n, input string tag);
        sample_stb = 1'b0;
        for (int i = 0; i < n; i++) begin
            bit_first = ~bit_first; bit_third = ~bit_third;
            gain_two = gain_two + 12'sd7;
            @(negedge clk);
            chk(out_valid == 1'b0, {tag, " R5 idle valid"}, longint'(out_valid), 0);
            chk(longint'(out_word) == last_word, {tag, " R5 idle hold"}, longint'(out_word), last_word);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid in reset", longint'(out_valid), 0);
        chk(out_word == '0, "R1 word in reset", longint'(out_word), 0);
        do_reset();
        chk(out_valid == 1'b0, "R1 valid after reset", longint'(out_valid), 0);
        chk(out_word == '0, "R1 word after reset", longint'(out_word), 0);
    endtask

    task automatic t_fill();
        do_reset();
        gain_two = 12'sd300; gain_three = -12'sd77;
        push(1, 0, 1, 0, "fill s0");
        push(0, 1, 1, 0, "fill s1");
        push(1, 1, 0, 0, "fill s2");
        chk(out_word == '0, "R1 word still zero before fill", longint'(out_word), 0);
        push(0, 0, 1, 0, "fill s3");
        push(1, 0, 0, 0, "fill s4");
    endtask

    task automatic t_constant();
        do_reset();
        gain_two = 12'sd1000; gain_three = -12'sd1500;
        for (int i = 0; i < 6; i++) push(1, 1, 1, 1, "ones");
        chk(longint'(out_word) == 256, "R2 all ones", longint'(out_word), 256);
        sample_stb = 1'b0;
        do_reset();
        for (int i = 0; i < 6; i++) push(0, 0, 0, 1, "zeros");
        chk(longint'(out_word) == -256, "R2 all zeros", longint'(out_word), -256);
        sample_stb = 1'b0;
    endtask

    // Integer model of the three loops feeding the combiner with consecutive strobes.
    task automatic t_loops();
        longint s1a = 0, s1b = 0, s2 = 0, s3 = 0, u;
        bit     b1, b2, b3;
        do_reset();
        gain_two = -12'sd256; gain_three = 12'sd512;
        for (int n = 0; n < 400; n++) begin
            u  = (n % 80 < 40) ? longint'((n % 40) * 10 - 200) : longint'(200 - (n % 40) * 10);
            b1 = (s1b >= 0);
            b2 = (s2 >= 0);
            b3 = (s3 >= 0);
            s1a = s1a + u - (b1 ? 256 : -256);
            s1b = s1b + s1a - (b1 ? 256 : -256);
            s2  = s2 + s1b - (b2 ? 1024 : -1024);
            s3  = s3 + s2 - (b3 ? 4096 : -4096);
            push(b1, b2, b3, (n != 399), "R8 loop stream");
        end
    endtask

    task automatic t_gaps();
        do_reset();
        gain_two = 12'sd123; gain_three = 12'sd45;
        for (int n = 0; n < 12; n++) begin
            push(n[0], n[1], n[2] ^ n[0], 0, "R5 gapped");
            idle(1 + (n % 3), "gap");
        end
    endtask

    task automatic t_coef_switch();
        do_reset();
        gain_two = 12'sd100; gain_three = 12'sd200;
        for (int n = 0; n < 5; n++) push(n[0], ~n[0], n[1], 0, "R7 pre");
        // Gains change on the strobe cycle itself.
        gain_two = -12'sd900; gain_three = 12'sd1700;
        push(1, 0, 0, 0, "R7 new gain same cycle");
        gain_two = 12'sd5; gain_three = -12'sd3;
        push(0, 1, 1, 0, "R7 second change");
    endtask

    task automatic t_extreme();
        do_reset();
        gain_two = -12'sd2048; gain_three = -12'sd2048;
        for (int n = 0; n < 10; n++) push(n[0], n[0], ~n[0], 0, "R6 extreme");
        gain_two = 12'sd2047; gain_three = 12'sd2047;
        for (int n = 0; n < 6; n++) push(~n[0], n[0], n[0], 0, "R6 extreme pos");
    endtask

    initial begin
        #1ms;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            ha[i] = 0; hb[i] = 0; hc[i] = 0;
        end
        nsamp = 0;
        last_word = 0;
        t_reset();
        t_fill();
        t_constant();
        t_loops();
        t_gaps();
        t_coef_switch();
        t_extreme();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule